// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits between six interrupt sources and a processor core and turns them into a single vectored request. The sources are two external lines, three timers and a serial port. Software controls the block through two byte-wide registers. The enable register holds one gate per source plus a master gate. The level register puts each source in either the low or the high priority group.

The block shows the winning request on `irq_req` with its entry address on `irq_vector`. When the core takes it, the core raises `irq_ack`, and the block records which priority group is now being serviced. When a handler finishes, the core pulses `irq_ret`, and the block releases the most recently entered group.

A low-group handler can be preempted by a high-group request but not by another low-group request. A high-group handler cannot be preempted at all. The block never clears a source flag. A flag that is still held after its handler returns is presented again.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, both registers read 0x00 and `irq_req` is 0.
- R2: In the enable register (`reg_addr`=0), bit 0 is external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2 and bit 7 the master gate. Bit 6 ignores writes and always reads 0. The level register (`reg_addr`=1) uses the same bit positions for the sources, 1 meaning high. Its bits 7:6 read 0. Read data appears on `reg_rdata` one clock after `reg_raddr` is applied.
- R3: With the master gate at 0 no request is ever presented. With the master gate at 1, a source is presented only if its own enable bit is 1.
- R4: The timer 2 request is `tmr2_ovf` OR `tmr2_ext`. The serial request is `ser_tx` OR `ser_rx`.
- R5: A change on `ext0_req`, `ext1_req`, the serial flags or the timer 2 flags reaches `irq_req` at the next clock edge. A change on `tmr0_flag` or `tmr1_flag` needs one extra clock.
- R6: The vectors are 0x03 (external 0), 0x0B (timer 0), 0x13 (external 1), 0x1B (timer 1), 0x23 (serial) and 0x2B (timer 2).
- R7: Any eligible high-group request wins over every low-group request. Within a group, the order from first to last is external 0, timer 0, external 1, timer 1, serial, timer 2.
- R8: An `irq_ack` taken while `irq_req` is 1 drops `irq_req` at the next edge. While a low-group handler is active, only high-group requests are presented.
- R9: While a high-group handler is active, no request is presented.
- R10: `irq_ret` releases only the highest active group. After the high group returns, a low-group handler that it preempted still blocks low-group requests.
- R11: The block never clears flags. A request still held once all handlers have returned is presented again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Write select: 0 enable, 1 level |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 1 | Read select: 0 enable, 1 level |
| reg_rdata | output | 8 | Registered read data |
| ext0_req | input | 1 | External request 0 |
| ext1_req | input | 1 | External request 1 |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external-event flag |
| ser_tx | input | 1 | Serial transmit-done flag |
| ser_rx | input | 1 | Serial receive-done flag |
| irq_req | output | 1 | Request to the core |
| irq_vector | output | 8 | Entry address of the presented request |
| irq_ack | input | 1 | Core takes the presented request |
| irq_ret | input | 1 | Core returns from a handler |

## Verification
The assertions assume two things about the core. It raises `irq_ack` only while `irq_req` is high, and it never pulses `irq_ack` and `irq_ret` in the same cycle. The bench keeps to this by acknowledging only after it has seen a request, and by issuing returns only on separate cycles with no acknowledge pending. Each source flag is also held steady for several clocks before it is sampled, so that the extra poll stage on the timer 0 and timer 1 flags has settled before a check is made.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 6;
  localparam int IDXW = $clog2(NSRC);

  typedef logic [NSRC-1:0] src_vec_t;

  // source index = enable/level bit position = polling rank
  localparam int SRC_EXT0 = 0;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_EXT1 = 2;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int SRC_TMR2 = 5;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          waddr,
  input  logic [DW-1:0] wdata,
  input  logic          raddr,
  output logic [DW-1:0] rdata,
  output src_vec_t      src_en,
  output logic          gbl_en,
  output src_vec_t      src_hi
);
  localparam int PAD_EN = DW - 1 - NSRC;
  localparam int PAD_PR = DW - NSRC;
  localparam logic [DW-1:0] EN_MASK = {1'b1, {PAD_EN{1'b0}}, {NSRC{1'b1}}};
  localparam logic [DW-1:0] PR_MASK = {{PAD_PR{1'b0}}, {NSRC{1'b1}}};

  logic [DW-1:0] en_q;
  logic [DW-1:0] pr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pr_q  <= '0;
      rdata <= '0;
    end else begin
      if (we && !waddr) en_q <= wdata & EN_MASK;
      if (we &&  waddr) pr_q <= wdata & PR_MASK;
      rdata <= raddr ? pr_q : en_q;
    end
  end

  assign src_en = en_q[NSRC-1:0];
  assign gbl_en = en_q[DW-1];
  assign src_hi = pr_q[NSRC-1:0];

  // R2: unused enable and level bits never show on the read port
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(raddr) |-> rdata[DW-2:NSRC] == '0) and
    ($past(raddr) |-> rdata[DW-1:NSRC] == '0));
endmodule

// File: rtl/irq_poll.sv
module irq_poll
  import irq_pkg::*;
(
  input  src_vec_t        req,
  input  src_vec_t        src_en,
  input  logic            gbl_en,
  input  src_vec_t        src_hi,
  input  logic            act_hi,
  input  logic            act_lo,
  output logic            found,
  output logic [IDXW-1:0] sel_idx,
  output logic            sel_lvl
);
  src_vec_t elig_hi, elig_lo;

  assign elig_hi = (gbl_en && !act_hi) ? (req & src_en & src_hi) : '0;
  assign elig_lo = (gbl_en && !act_hi && !act_lo) ? (req & src_en & ~src_hi) : '0;

  always_comb begin
    found   = 1'b0;
    sel_idx = '0;
    sel_lvl = 1'b0;
    // scan downwards so the lowest index (first in polling order) wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_lo[i]) begin
        found   = 1'b1;
        sel_idx = IDXW'(i);
        sel_lvl = 1'b0;
      end
    end
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) begin
        found   = 1'b1;
        sel_idx = IDXW'(i);
        sel_lvl = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_lvl,
  input  logic ret,
  output logic act_hi,
  output logic act_lo
);
  logic clr_hi, clr_lo;

  assign clr_hi = ret && act_hi;
  assign clr_lo = ret && !act_hi && act_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      act_hi <= (act_hi && !clr_hi) || (take && take_lvl);
      act_lo <= (act_lo && !clr_lo) || (take && !take_lvl);
    end
  end

  // R10: a return releases the high group first and leaves the low group
  p_ret_high_first_r10: assert property (@(posedge clk) disable iff (rst)
    (ret && act_hi && act_lo && !take) |=> (!act_hi && act_lo));

  // R8: a taken low request can only be accepted when no high handler runs
  p_take_low_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (take && !take_lvl) |-> !act_hi && !act_lo);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   VEC_BASE = 8'h03,
  parameter logic [DW-1:0]   VEC_STEP = 8'h08
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_raddr,
  output logic [DW-1:0] reg_rdata,
  input  logic          ext0_req,
  input  logic          ext1_req,
  input  logic          tmr0_flag,
  input  logic          tmr1_flag,
  input  logic          tmr2_ovf,
  input  logic          tmr2_ext,
  input  logic          ser_tx,
  input  logic          ser_rx,
  output logic          irq_req,
  output logic [DW-1:0] irq_vector,
  input  logic          irq_ack,
  input  logic          irq_ret
);
  src_vec_t        src_en, src_hi, req;
  logic            gbl_en;
  logic            tmr0_q, tmr1_q;
  logic            act_hi, act_lo;
  logic            found, sel_lvl, lvl_q, take;
  logic [IDXW-1:0] sel_idx;

  irq_regs #(.DW(DW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (reg_we),
    .waddr  (reg_addr),
    .wdata  (reg_wdata),
    .raddr  (reg_raddr),
    .rdata  (reg_rdata),
    .src_en (src_en),
    .gbl_en (gbl_en),
    .src_hi (src_hi)
  );

  // timer 0/1 flags are polled one cycle late; the rest go straight in
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr0_q <= 1'b0;
      tmr1_q <= 1'b0;
    end else begin
      tmr0_q <= tmr0_flag;
      tmr1_q <= tmr1_flag;
    end
  end

  always_comb begin
    req           = '0;
    req[SRC_EXT0] = ext0_req;
    req[SRC_TMR0] = tmr0_q;
    req[SRC_EXT1] = ext1_req;
    req[SRC_TMR1] = tmr1_q;
    req[SRC_SER]  = ser_tx | ser_rx;
    req[SRC_TMR2] = tmr2_ovf | tmr2_ext;
  end

  irq_poll u_poll (
    .req     (req),
    .src_en  (src_en),
    .gbl_en  (gbl_en),
    .src_hi  (src_hi),
    .act_hi  (act_hi),
    .act_lo  (act_lo),
    .found   (found),
    .sel_idx (sel_idx),
    .sel_lvl (sel_lvl)
  );

  assign take = irq_ack && irq_req;

  irq_nest u_nest (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_lvl (lvl_q),
    .ret      (irq_ret),
    .act_hi   (act_hi),
    .act_lo   (act_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      irq_vector <= '0;
      lvl_q      <= 1'b0;
    end else begin
      irq_req <= found && !take;
      if (found) begin
        irq_vector <= VEC_BASE + DW'(sel_idx) * VEC_STEP;
        lvl_q      <= sel_lvl;
      end
    end
  end

  // R3: master gate off means nothing is presented next cycle
  p_gate_off_r3: assert property (@(posedge clk) disable iff (rst)
    !gbl_en |=> !irq_req);

  // R8: acknowledge removes the request at the next edge
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_req);

  // R9: an active high handler blocks everything
  p_hi_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    act_hi |=> !irq_req);

  // R6: a presented vector is always one of the six entry addresses
  p_vec_legal_r6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vector[2:0] == 3'd3 && irq_vector <= 8'h2B));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_addr = 1'b0, reg_raddr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext0_req = 0, ext1_req = 0, tmr0_flag = 0, tmr1_flag = 0;
  logic       tmr2_ovf = 0, tmr2_ext = 0, ser_tx = 0, ser_rx = 0;
  logic       irq_req, irq_ack = 0, irq_ret = 0;
  logic [7:0] irq_vector;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .ext0_req(ext0_req), .ext1_req(ext1_req), .tmr0_flag(tmr0_flag),
    .tmr1_flag(tmr1_flag), .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_raddr = a;
    cyc(2);
    d = reg_rdata;
  endtask

  // flag order: ext0,tmr0,ext1,tmr1,ser_tx,ser_rx,tmr2_ovf,tmr2_ext
  task automatic flags(input logic [7:0] f);
    ext0_req = f[0]; tmr0_flag = f[1]; ext1_req = f[2]; tmr1_flag = f[3];
    ser_tx = f[4]; ser_rx = f[5]; tmr2_ovf = f[6]; tmr2_ext = f[7];
  endtask

  // model of R3, R4, R6, R7 with no handler active: {found, vector}
  function automatic logic [8:0] pick(input logic [7:0] en, input logic [7:0] pr,
                                      input logic [7:0] f);
    logic [5:0] r;
    r = {f[6] | f[7], f[4] | f[5], f[3], f[2], f[1], f[0]};
    for (int l = 1; l >= 0; l--)
      for (int i = 0; i < 6; i++)
        if (en[7] && en[i] && r[i] && (pr[i] == l[0]))
          return {1'b1, 8'(8'h03 + 8 * i)};
    return 9'h0;
  endfunction

  task automatic expect_req(input logic [8:0] e, input string tag);
    chk(irq_req == e[8], tag, irq_req, e[8]);
    if (e[8]) chk(irq_vector == e[7:0], tag, irq_vector, e[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, en, pr, f;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1
    chk(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
    rd(1'b0, d); chk(d == 8'h00, "R1 enable reset", d, 0);
    rd(1'b1, d); chk(d == 8'h00, "R1 level reset", d, 0);
    // R2
    wr(1'b0, 8'hFF); rd(1'b0, d); chk(d == 8'hBF, "R2 reserved enable bit", d, 8'hBF);
    wr(1'b1, 8'hFF); rd(1'b1, d); chk(d == 8'h3F, "R2 level upper bits", d, 8'h3F);
    // R3: master gate off
    wr(1'b1, 8'h00); wr(1'b0, 8'h3F); flags(8'hFF); cyc(3);
    chk(irq_req == 1'b0, "R3 master gate off", irq_req, 0);
    wr(1'b0, 8'h84); cyc(3);
    expect_req({1'b1, 8'h13}, "R3 single source gated");
    // R4
    wr(1'b0, 8'hFF);
    flags(8'h80); cyc(3); expect_req({1'b1, 8'h2B}, "R4 timer2 ext flag");
    flags(8'h20); cyc(3); expect_req({1'b1, 8'h23}, "R4 serial rx");
    flags(8'h10); cyc(3); expect_req({1'b1, 8'h23}, "R4 serial tx");
    // R5 timing
    flags(8'h00); cyc(3);
    flags(8'h08); cyc(1);
    chk(irq_req == 1'b0, "R5 timer1 not yet", irq_req, 0);
    cyc(1); expect_req({1'b1, 8'h1B}, "R5 timer1 after two edges");
    flags(8'h00); cyc(3);
    flags(8'h40); cyc(1); expect_req({1'b1, 8'h2B}, "R5 timer2 after one edge");
    // R6, R7 ordering
    flags(8'hFF); cyc(3); expect_req({1'b1, 8'h03}, "R7 low group order");
    wr(1'b1, 8'h20); cyc(2); expect_req({1'b1, 8'h2B}, "R7 high beats order");
    wr(1'b1, 8'h18); cyc(2); expect_req({1'b1, 8'h1B}, "R7 high group order");
    flags(8'h02); wr(1'b1, 8'h00); cyc(3); expect_req({1'b1, 8'h0B}, "R6 timer0 vector");
    // random phase, no handler active
    for (int k = 0; k < 60; k++) begin
      en = 8'($urandom) & 8'hBF;
      pr = 8'($urandom) & 8'h3F;
      f  = 8'($urandom);
      wr(1'b0, en); wr(1'b1, pr); flags(f); cyc(3);
      expect_req(pick(en, pr, f), "R7 random mix");
    end
    // nesting
    flags(8'h00); wr(1'b0, 8'hFF); wr(1'b1, 8'h20); cyc(3);
    flags(8'h04); cyc(2); expect_req({1'b1, 8'h13}, "R8 low presented");
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    chk(irq_req == 1'b0, "R8 drop after ack", irq_req, 0);
    flags(8'h05); cyc(3);
    chk(irq_req == 1'b0, "R8 low blocked by low", irq_req, 0);
    flags(8'h45); cyc(1); expect_req({1'b1, 8'h2B}, "R8 high preempts low");
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    cyc(3);
    chk(irq_req == 1'b0, "R9 high handler blocks", irq_req, 0);
    irq_ret = 1'b1; cyc(1); irq_ret = 1'b0; cyc(1);
    expect_req({1'b1, 8'h2B}, "R10 high released only");
    flags(8'h05); cyc(3);
    chk(irq_req == 1'b0, "R10 low still active", irq_req, 0);
    irq_ret = 1'b1; cyc(1); irq_ret = 1'b0; cyc(1);
    expect_req({1'b1, 8'h03}, "R11 held flag presented again");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule